// File: doc/BRIEF.md
# Multiprocessor UART Receive Filter

This block is the receive half of an asynchronous serial port. It takes 8-bit or 9-bit frames from an oversampled line, and its end-of-frame logic decides in hardware whether a frame reaches software. The line is sampled sixteen times per bit. Each bit is decided by a majority of three samples around its centre, and a start bit that has gone high again by mid-bit is thrown away as noise. The oversampling strobe comes from a baud source outside the block.

In the 9-bit modes the ninth bit tells an address byte (ninth bit 1) from a data byte (ninth bit 0). When the filter is enabled, a slave receives only address bytes that hit its own masked address or the broadcast address. Once software has seen its address, it turns the filter off to take the data bytes that follow. A frame that fails the end-of-frame test is dropped without a trace: the buffer, the ninth-bit register and the receive flag all keep their values. The framing-error flag is separate. It reports every low stop bit and stays set until software clears it.

Top module: `mp_uart_rx_filter`

## Requirements
- R1: After reset the receive buffer and ninth-bit register read 0, and the receive flag and framing-error flag are clear.
- R2: An accepted frame writes its data bits (sent LSB first) into the buffer and sets the receive flag. In modes 2 and 3 (mode = 2'b10 or 2'b11) the ninth-bit register takes the ninth bit. In mode 1 (mode = 2'b01, 8 data bits) it takes the sampled stop bit.
- R3: A frame that ends while the receive flag is set is discarded: buffer, ninth-bit register and flag keep their values.
- R4: With filt_en = 0, every frame that ends while the flag is clear is accepted, whatever its ninth bit.
- R5: With filt_en = 1 in mode 2 or 3, a frame whose ninth bit is 0 is discarded.
- R6: With filt_en = 1 in mode 2 or 3, a frame whose ninth bit is 1 is accepted when (data & addr_mask) == (slave_addr & addr_mask), unless it matches the broadcast address of R7. Otherwise it is discarded.
- R7: With filt_en = 1 in mode 2 or 3, a frame whose ninth bit is 1 is also accepted when every bit set in (slave_addr | addr_mask) is also set in the received data.
- R8: In mode 1 with filt_en = 1, a frame with a low stop bit is discarded. With filt_en = 0 the same frame is accepted.
- R9: A low stop bit sets frame_err whatever the filter, mode or flag state. Only clr_ferr clears frame_err, and only clr_flag clears rx_flag.
- R10: In mode 0 (mode = 2'b00) the receiver ignores the line, so no output changes for any value of filt_en.
- R11: A start bit that is high by mid-bit is rejected without effect. A one-sample glitch at a bit's centre does not change the bit's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| mode | input | 2 | 0 shift (receiver off), 1 eight-bit, 2/3 nine-bit |
| filt_en | input | 1 | Enables end-of-frame filtering |
| slave_addr | input | 8 | This node's address |
| addr_mask | input | 8 | Address mask, 0 bits are don't-care |
| clr_flag | input | 1 | Clears the receive flag |
| clr_ferr | input | 1 | Clears the framing-error flag |
| rx_data | output | 8 | Receive buffer |
| rx_bit9 | output | 1 | Ninth-bit register |
| rx_flag | output | 1 | Receive flag |
| frame_err | output | 1 | Framing-error flag |

## Verification
Most internal faults show up at the ports within one frame. A wrong bit counter or sample phase puts shifted or inverted data in rx_data. A wrong compare either raises rx_flag on a frame that a correct design drops, or leaves it low on a frame that should be taken. The reference model changes its expected outputs once per frame and compares all four outputs on every clock while the line is idle, so a fault is reported within a few cycles of the first frame it affects. Faults in the drop path show only as values that fail to stay put. The bench therefore sends frames while the flag is still set and checks that the buffer is unchanged afterwards.

// File: rtl/mpr_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the multiprocessor receive filter.
// Assumes mode encodings: 0 shift (receiver off), 1 eight-bit, 2/3 nine-bit.
package mpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_t;

    localparam logic [1:0] MODE_SHIFT = 2'b00;
    localparam logic [1:0] MODE_8BIT  = 2'b01;

    // Two-of-three vote over the samples taken around a bit centre.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mpr_line_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module mpr_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Moves the line value one stage further from the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[i] <= 1'b1;
                end else begin
                    if (i == 0) begin
                        q[i] <= din;
                    end else begin
                        q[i] <= q[(i == 0) ? 0 : i-1];
                    end
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];

endmodule

// File: rtl/mpr_frame_rx.sv
`timescale 1ns/1ps
// Frame deserializer. Counts OS_RATE ticks per bit and votes over three
// samples around the bit centre. It drops false starts, shifts in data
// LSB first, optionally takes a ninth bit, and pulses done at the stop
// bit centre. Assumes os_tick is a one-cycle strobe and mode is stable
// for the length of a frame.
module mpr_frame_rx
    import mpr_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              os_tick,
    input  logic [1:0]        mode,
    output logic              done,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              stop_ok
);

    localparam int unsigned CNT_W = $clog2(OS_RATE);
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int unsigned MID_A = OS_RATE/2 - 1;
    localparam int unsigned MID_B = OS_RATE/2;
    localparam int unsigned MID_C = OS_RATE/2 + 1;
    localparam int unsigned LAST  = OS_RATE - 1;

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              s_a, s_b, nb;
    logic              vote;

    // Majority of the two stored samples and the current one.
    always_comb vote = maj3(s_a, s_b, line);

    // Bit timing, sampling, shifting and frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
            nb      <= 1'b0;
            done    <= 1'b0;
            data_o  <= '0;
            bit9_o  <= 1'b0;
            stop_ok <= 1'b1;
        end else begin
            done <= 1'b0;
            if (mode == MODE_SHIFT) begin
                state <= ST_IDLE;
            end else if (os_tick) begin
                if (state == ST_IDLE) begin
                    if (!line) begin
                        state <= ST_START;
                        cnt   <= CNT_W'(1);
                    end
                end else begin
                    cnt <= (cnt == CNT_W'(LAST)) ? '0 : cnt + 1'b1;
                    if (cnt == CNT_W'(MID_A)) s_a <= line;
                    if (cnt == CNT_W'(MID_B)) s_b <= line;
                    if (cnt == CNT_W'(MID_C)) begin
                        case (state)
                            ST_START: if (vote) state <= ST_IDLE;
                            ST_DATA:  shreg <= {vote, shreg[DATA_W-1:1]};
                            ST_NINTH: nb <= vote;
                            ST_STOP: begin
                                done    <= 1'b1;
                                stop_ok <= vote;
                                data_o  <= shreg;
                                bit9_o  <= mode[1] ? nb : vote;
                                state   <= ST_IDLE;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                    if (cnt == CNT_W'(LAST)) begin
                        case (state)
                            ST_START: begin
                                state <= ST_DATA;
                                idx   <= '0;
                            end
                            ST_DATA: begin
                                idx <= idx + 1'b1;
                                if (idx == IDX_W'(DATA_W-1)) begin
                                    state <= mode[1] ? ST_NINTH : ST_STOP;
                                end
                            end
                            ST_NINTH: state <= ST_STOP;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mpr_accept_gate.sv
`timescale 1ns/1ps
// End-of-frame decision. Compares the frame against the masked given
// address and the broadcast address bit by bit, then combines the result
// with the flag state, the filter enable and the mode. Purely combinational.
module mpr_accept_gate
    import mpr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [1:0]        mode,
    input  logic              filt_en,
    input  logic              flag,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] addr_mask,
    output logic              accept
);

    logic [DATA_W-1:0] given_bit, bcast_bit;
    logic              given_hit, bcast_hit, pass;

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_cmp
            // Per-bit given and broadcast match.
            always_comb begin
                given_bit[i] = !addr_mask[i] || (data[i] == slave_addr[i]);
                bcast_bit[i] = !(slave_addr[i] | addr_mask[i]) || data[i];
            end
        end
    endgenerate

    // Combine the address hits with the mode and filter rules.
    always_comb begin
        given_hit = &given_bit;
        bcast_hit = &bcast_bit;
        if (!filt_en)      pass = 1'b1;
        else if (mode[1])  pass = bit9 && (given_hit || bcast_hit);
        else               pass = stop_ok;
        accept = !flag && (mode != MODE_SHIFT) && pass;
    end

endmodule

// File: rtl/mp_uart_rx_filter.sv
`timescale 1ns/1ps
// Top of the multiprocessor receive filter. Synchronizes the line,
// deserializes frames and holds the software-visible registers. A frame
// is loaded only when the accept gate allows it. Assumes the
// configuration inputs change only while the line is idle.
module mp_uart_rx_filter #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OS_RATE     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic [1:0]        mode,
    input  logic              filt_en,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              clr_flag,
    input  logic              clr_ferr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              frame_err
);

    logic              line_s;
    logic              fr_done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_bit9;
    logic              fr_stop_ok;
    logic              accept;

    mpr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    mpr_frame_rx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line_s),
        .os_tick (os_tick),
        .mode    (mode),
        .done    (fr_done),
        .data_o  (fr_data),
        .bit9_o  (fr_bit9),
        .stop_ok (fr_stop_ok)
    );

    mpr_accept_gate #(.DATA_W(DATA_W)) u_gate (
        .mode       (mode),
        .filt_en    (filt_en),
        .flag       (rx_flag),
        .data       (fr_data),
        .bit9       (fr_bit9),
        .stop_ok    (fr_stop_ok),
        .slave_addr (slave_addr),
        .addr_mask  (addr_mask),
        .accept     (accept)
    );

    // Buffer and ninth-bit register load on an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
        end else if (fr_done && accept) begin
            rx_data <= fr_data;
            rx_bit9 <= fr_bit9;
        end
    end

    // Receive flag: set on an accepted frame, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rx_flag <= 1'b0;
        else if (fr_done && accept) rx_flag <= 1'b1;
        else if (clr_flag)          rx_flag <= 1'b0;
    end

    // Framing error: set on a low stop bit, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                     frame_err <= 1'b0;
        else if (fr_done && !fr_stop_ok) frame_err <= 1'b1;
        else if (clr_ferr)              frame_err <= 1'b0;
    end

endmodule

// File: rtl/mpr_checker.sv
`timescale 1ns/1ps
// Property checker for mp_uart_rx_filter, attached through bind.
module mpr_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              filt_en,
    input logic              clr_flag,
    input logic              clr_ferr,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              rx_flag,
    input logic              frame_err,
    input logic              fr_done,
    input logic              fr_bit9,
    input logic              fr_stop_ok
);

    AST_FLAG_ONLY_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_flag) |-> $past(fr_done)); // R2
    AST_FULL_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n) fr_done && rx_flag |=> rx_flag && $stable(rx_data) && $stable(rx_bit9)); // R3
    AST_DATA_BYTE_FILTERED: assert property (@(posedge clk) disable iff (!rst_n) fr_done && filt_en && mode[1] && !fr_bit9 && !rx_flag |=> !rx_flag); // R5
    AST_BAD_STOP_FILTERED: assert property (@(posedge clk) disable iff (!rst_n) fr_done && filt_en && (mode == 2'b01) && !fr_stop_ok && !rx_flag |=> !rx_flag); // R8
    AST_FERR_ON_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n) fr_done && !fr_stop_ok |=> frame_err); // R9
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) frame_err && !clr_ferr |=> frame_err); // R9
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) clr_flag && !fr_done |=> !rx_flag); // R9
    AST_SHIFT_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b00) |=> !fr_done); // R10

endmodule

bind mp_uart_rx_filter mpr_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_mp_uart_rx_filter.sv
`timescale 1ns/1ps
module sim_mp_uart_rx_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] mode = 2'b11;
    logic       filt_en = 1'b0;
    logic [7:0] slave_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       clr_flag = 1'b0;
    logic       clr_ferr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_flag, frame_err;

    int    n_checks = 0;
    int    n_fails = 0;
    bit    chk_en = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // Reference state of the four outputs.
    logic [7:0] exp_data = 8'h00;
    logic       exp_b9 = 1'b0, exp_flag = 1'b0, exp_ferr = 1'b0;

    mp_uart_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .mode(mode), .filt_en(filt_en), .slave_addr(slave_addr),
        .addr_mask(addr_mask), .clr_flag(clr_flag), .clr_ferr(clr_ferr),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
        .frame_err(frame_err)
    );

    always #2.5 clk = ~clk;

    // 16x strobe: one cycle high in every four.
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 os_tick = 1'b1;
            @(posedge clk);
            #1 os_tick = 1'b0;
        end
    end

    task automatic compare(input string req);
        n_checks++;
        if (rx_data !== exp_data || rx_bit9 !== exp_b9 || rx_flag !== exp_flag || frame_err !== exp_ferr) begin
            n_fails++;
            $display("FAIL %s: actual data=%h b9=%b flag=%b ferr=%b expected data=%h b9=%b flag=%b ferr=%b",
                     req, rx_data, rx_bit9, rx_flag, frame_err, exp_data, exp_b9, exp_flag, exp_ferr);
        end
    endtask

    // Compare against the model on every clock while the line is quiet.
    always @(negedge clk) if (chk_en) compare(cur_req);

    task automatic wait_tick();
        do @(posedge clk); while (os_tick !== 1'b1);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) wait_tick();
    endtask

    task automatic drive_bit(input logic v, input bit glitch);
        rx_line = v;
        if (glitch) begin
            ticks(8);
            rx_line = ~v;
            ticks(1);
            rx_line = v;
            ticks(7);
        end else begin
            ticks(16);
        end
    endtask

    // Behavioural end-of-frame decision from the requirements.
    task automatic model(input logic [7:0] d, input logic b9, input logic stp);
        logic [7:0] bc;
        bit given, bcast, pass;
        bc    = slave_addr | addr_mask;
        given = ((d ^ slave_addr) & addr_mask) == 8'h00;
        bcast = (d & bc) == bc;
        if (mode == 2'b00) return;
        if (!stp) exp_ferr = 1'b1;
        if (!filt_en)     pass = 1'b1;
        else if (mode[1]) pass = b9 && (given || bcast);
        else              pass = stp;
        if (!exp_flag && pass) begin
            exp_data = d;
            exp_b9   = mode[1] ? b9 : stp;
            exp_flag = 1'b1;
        end
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic stp, input int glitch_at, input string req);
        chk_en = 1'b0;
        cur_req = req;
        wait_tick();
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i], glitch_at == i);
        if (mode[1]) drive_bit(b9, 1'b0);
        drive_bit(stp, 1'b0);
        rx_line = 1'b1;
        ticks(32);
        model(d, b9, stp);
        chk_en = 1'b1;
        ticks(4);
    endtask

    task automatic clear(input bit f, input bit e, input string req);
        chk_en = 1'b0;
        cur_req = req;
        @(posedge clk); #1;
        clr_flag = f;
        clr_ferr = e;
        @(posedge clk); #1;
        clr_flag = 1'b0;
        clr_ferr = 1'b0;
        if (f) exp_flag = 1'b0;
        if (e) exp_ferr = 1'b0;
        chk_en = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic cfg(input logic [1:0] m, input logic f, input logic [7:0] sa, input logic [7:0] mk);
        @(posedge clk); #1;
        mode = m; filt_en = f; slave_addr = sa; addr_mask = mk;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state");
        chk_en = 1'b1;

        // R4, R2: filter off, data byte and address byte both taken.
        cfg(2'b11, 1'b0, 8'h00, 8'h00);
        send(8'hA5, 1'b0, 1'b1, -1, "R4 filter off data byte / R2 load");
        clear(1'b1, 1'b0, "R9 clr_flag");
        send(8'h3C, 1'b1, 1'b1, -1, "R4 filter off address byte / R2");
        // R3: flag still set, next frame dropped.
        send(8'h11, 1'b0, 1'b1, -1, "R3 full flag drops frame");
        clear(1'b1, 1'b0, "R9 clr_flag");

        // Filter on, nine-bit mode 2, slave 0x5A mask 0xF0.
        cfg(2'b10, 1'b1, 8'h5A, 8'hF0);
        send(8'h55, 1'b0, 1'b1, -1, "R5 data byte filtered");
        send(8'h5F, 1'b1, 1'b1, -1, "R6 given address hit");
        clear(1'b1, 1'b0, "R9 clr_flag");
        send(8'h6A, 1'b1, 1'b1, -1, "R6 given address miss");
        send(8'hFB, 1'b1, 1'b1, -1, "R7 broadcast hit");
        clear(1'b1, 1'b0, "R9 clr_flag");
        send(8'hFF, 1'b1, 1'b1, -1, "R7 broadcast all ones");
        send(8'h5A, 1'b1, 1'b1, -1, "R3 drop while flag set");
        clear(1'b1, 1'b0, "R9 clr_flag");

        // Mode 1 stop-bit rules and framing error.
        cfg(2'b01, 1'b1, 8'h5A, 8'hF0);
        send(8'h81, 1'b0, 1'b0, -1, "R8 bad stop dropped / R9 ferr set");
        clear(1'b1, 1'b0, "R9 clr_flag leaves frame_err");
        clear(1'b0, 1'b1, "R9 clr_ferr");
        send(8'h42, 1'b0, 1'b1, -1, "R2 mode1 bit9 holds stop");
        clear(1'b1, 1'b0, "R9 clr_flag");
        cfg(2'b01, 1'b0, 8'h5A, 8'hF0);
        send(8'h24, 1'b0, 1'b0, -1, "R8 filter off bad stop accepted");
        send(8'h99, 1'b0, 1'b0, -1, "R9 ferr with flag set");
        clear(1'b1, 1'b1, "R9 clear both");

        // R10: shift mode ignores the line, filter on or off.
        cfg(2'b00, 1'b1, 8'h5A, 8'hF0);
        send(8'h5F, 1'b1, 1'b0, -1, "R10 mode0 filter on");
        cfg(2'b00, 1'b0, 8'h00, 8'h00);
        send(8'hC3, 1'b0, 1'b1, -1, "R10 mode0 filter off");

        // R11: false start, then a mid-bit glitch.
        cfg(2'b11, 1'b0, 8'h00, 8'h00);
        chk_en = 1'b0;
        cur_req = "R11 false start";
        wait_tick();
        rx_line = 1'b0;
        ticks(3);
        rx_line = 1'b1;
        ticks(40);
        chk_en = 1'b1;
        ticks(4);
        send(8'h96, 1'b1, 1'b1, 3, "R11 centre glitch ignored");
        clear(1'b1, 1'b0, "R9 clr_flag");
        send(8'h0F, 1'b0, 1'b1, 0, "R11 glitch on bit 0");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule